// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Tags

This block turns an asynchronous serial line back into parallel characters. An external divider supplies a strobe at sixteen times the bit rate. The receiver uses it to find a valid start bit and then samples each data bit, the optional parity bit and the stop bit at the centre of its bit period. Each finished character goes into a small receive queue. Every queue entry carries its own error tags: parity mismatch, bad stop bit, line break and overrun. Software can therefore tell which character went wrong, and does not depend on a single sticky status word.

The receiver accepts a new character only when both the module enable and the receive enable are high. Dropping either one while a character is in flight does not cut the character short. The frame format is captured when the start bit is detected. The format covers a data length of five to eight bits, parity on or off, and odd or even parity. The read side works as a show-ahead queue. The head entry is visible on the outputs whenever the queue is not empty, and a one-cycle read strobe removes it.

Top module: `uart_rx_tagged`

## Requirements
- R1: While `en` or `rx_en` is low, a low level on `rxd` starts no character and nothing is written to the queue.
- R2: A low pulse on `rxd` that has ended by the eighth tick after it is seen (the middle of the start bit) is discarded, and the receiver goes back to idle without writing an entry.
- R3: Data bits are sampled at mid-bit and assembled least significant bit first. `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The result is right-aligned in `rd_data`, and the unused upper bits read zero.
- R4: With `cfg_par_en` high, one parity bit follows the data bits. `cfg_par_odd`=0 expects an even count of ones over the data and parity bits, and 1 expects an odd count. On a mismatch, `rd_par_err` is set for that character.
- R5: A stop bit sampled low sets `rd_frm_err` for that character. The character is still stored.
- R6: If every sample of a frame is low, including the start, data, parity and stop samples, one entry is stored with data zero and both `rd_brk` and `rd_frm_err` set. No new start is accepted until `rxd` has returned high.
- R7: If a character completes while the queue holds DEPTH entries, the character is dropped and `rd_ovr` is set on the most recently stored entry.
- R8: Clearing `en` or `rx_en` after a start bit has been accepted still lets that character complete and be stored.
- R9: Entries are read in arrival order. `rd_empty` is high exactly when the queue holds no entry, and `rd_en` while `rd_empty` is high has no effect.
- R10: After reset the queue is empty and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial input line, idle high |
| tick | input | 1 | One-cycle strobe at OVS times the bit rate |
| cfg_len | input | 2 | Data length code: 0..3 selects 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_en | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry data, right-aligned |
| rd_par_err | output | 1 | Head entry parity error |
| rd_frm_err | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break condition |
| rd_ovr | output | 1 | Head entry overrun: the character after it was lost |
| rd_empty | output | 1 | Queue holds no entry |

## Verification
On every cycle, the assertions check that a start bit that is high at its midpoint sends the receiver back to idle, and that the bit counter moves only on oversampling ticks. They also check that a break entry leaves the receiver waiting for the line to go high, that a full queue never grows, and that a read of an empty queue changes nothing. Other behaviour appears only in the bench's directed scenarios. These cover the LSB-first assembly for each data length, the parity polarity and the error tag, and framing and break tagging. They also cover a character that finishes after the enable is dropped, and the overrun tag that lands on the last stored entry.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int unsigned RX_DW = 8;

    typedef struct packed {
        logic             brk;
        logic             ovr;
        logic             frm;
        logic             par;
        logic [RX_DW-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_HOLD
    } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go,
    input  logic      line,
    input  logic      tick,
    input  logic [1:0] cfg_len,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    output logic      push,
    output rx_entry_t entry
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    typedef struct packed {
        rx_state_e        st;
        logic [CW-1:0]    cnt;
        logic [2:0]       nbit;
        logic [RX_DW-1:0] sh;
        logic [1:0]       len;
        logic             pen;
        logic             podd;
        logic             px;
        logic             allz;
    } frame_t;

    frame_t fr_d, fr_q;
    logic   samp;

    always_comb begin
        fr_d = fr_q;
        samp = tick && (fr_q.cnt == LAST);
        unique case (fr_q.st)
            S_IDLE: begin
                if (go && !line) begin
                    fr_d.st   = S_START;
                    fr_d.cnt  = '0;
                    fr_d.nbit = '0;
                    fr_d.sh   = '0;
                    fr_d.len  = cfg_len;
                    fr_d.pen  = cfg_par_en;
                    fr_d.podd = cfg_par_odd;
                    fr_d.px   = 1'b0;
                    fr_d.allz = 1'b1;
                end
            end
            S_START: begin
                if (tick) begin
                    if (fr_q.cnt == MID) begin
                        fr_d.cnt = '0;
                        fr_d.st  = line ? S_IDLE : S_DATA;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            S_DATA: begin
                if (samp) begin
                    fr_d.cnt  = '0;
                    fr_d.sh   = {line, fr_q.sh[RX_DW-1:1]};
                    fr_d.px   = fr_q.px ^ line;
                    fr_d.allz = fr_q.allz & ~line;
                    if (fr_q.nbit == (3'd4 + {1'b0, fr_q.len}))
                        fr_d.st = fr_q.pen ? S_PAR : S_STOP;
                    else
                        fr_d.nbit = fr_q.nbit + 1'b1;
                end else if (tick) begin
                    fr_d.cnt = fr_q.cnt + 1'b1;
                end
            end
            S_PAR: begin
                if (samp) begin
                    fr_d.cnt  = '0;
                    fr_d.px   = fr_q.px ^ line;
                    fr_d.allz = fr_q.allz & ~line;
                    fr_d.st   = S_STOP;
                end else if (tick) begin
                    fr_d.cnt = fr_q.cnt + 1'b1;
                end
            end
            S_STOP: begin
                if (samp) begin
                    fr_d.cnt = '0;
                    fr_d.st  = line ? S_IDLE : S_HOLD;
                end else if (tick) begin
                    fr_d.cnt = fr_q.cnt + 1'b1;
                end
            end
            S_HOLD: begin
                if (line) fr_d.st = S_IDLE;
            end
            default: fr_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '{st: S_IDLE, default: '0};
        else        fr_q <= fr_d;
    end

    always_comb begin
        push       = (fr_q.st == S_STOP) && samp;
        entry.data = fr_q.sh >> (2'd3 - fr_q.len);
        entry.par  = fr_q.pen & (fr_q.px ^ fr_q.podd);
        entry.frm  = ~line;
        entry.brk  = fr_q.allz & ~line;
        entry.ovr  = 1'b0;
    end

    // R2: a start bit that is high at its midpoint is dropped
    p_start_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == S_START && tick && fr_q.cnt == MID && line) |=> (fr_q.st == S_IDLE));

    // R3: the bit-position counter advances only on oversampling ticks
    p_cnt_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st != S_IDLE && fr_q.st != S_HOLD && !tick) |=> $stable(fr_q.cnt));

    // R6: after a break entry the receiver waits for the line to go high
    p_hold_after_break_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && entry.brk) |=> (fr_q.st == S_HOLD));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t din,
    input  logic      pop,
    output rx_entry_t dout,
    output logic      empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [AW:0]           cnt;
    } fifo_t;

    fifo_t ff_d, ff_q;
    logic  full, do_push, do_pop;

    always_comb begin
        ff_d    = ff_q;
        full    = (ff_q.cnt == FULL_CNT);
        empty   = (ff_q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (push && full)
            ff_d.mem[ff_q.wp - 1'b1].ovr = 1'b1;
        if (do_push) begin
            ff_d.mem[ff_q.wp] = din;
            ff_d.wp = ff_q.wp + 1'b1;
        end
        if (do_pop)
            ff_d.rp = ff_q.rp + 1'b1;
        ff_d.cnt = ff_q.cnt + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign dout = ff_q.mem[ff_q.rp];

    // R7: a completion into a full queue never grows it
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(ff_q.cnt));

    // R9: reading an empty queue changes nothing
    p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (ff_q.cnt == '0 && $stable(ff_q.rp)));
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
    import uart_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 8,
    parameter int SYNC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       rx_en,
    input  logic       rxd,
    input  logic       tick,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_par_err,
    output logic       rd_frm_err,
    output logic       rd_brk,
    output logic       rd_ovr,
    output logic       rd_empty
);
    logic      line_s;
    logic      push;
    rx_entry_t entry_w, head;

    uart_rx_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
    );

    uart_rx_frame #(.OVS(OVS)) u_frame (
        .clk(clk), .rst_n(rst_n), .go(en & rx_en), .line(line_s), .tick(tick),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .push(push), .entry(entry_w)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(entry_w),
        .pop(rd_en), .dout(head), .empty(rd_empty)
    );

    assign rd_data    = head.data;
    assign rd_par_err = head.par;
    assign rd_frm_err = head.frm;
    assign rd_brk     = head.brk;
    assign rd_ovr     = head.ovr;
endmodule

// File: tb/uart_rx_tagged_test.sv
module uart_rx_tagged_test;
    localparam int BIT = 64; // 16 ticks of 4 clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1, rx_en = 1'b1, rxd = 1'b1, tick = 1'b0, rd_en = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic [7:0] rd_data;
    logic rd_par_err, rd_frm_err, rd_brk, rd_ovr, rd_empty;
    logic [1:0] tdiv = 2'd0;
    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd3);
    end

    uart_rx_tagged uut (
        .clk(clk), .rst_n(rst_n), .en(en), .rx_en(rx_en), .rxd(rxd), .tick(tick),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_en(rd_en), .rd_data(rd_data), .rd_par_err(rd_par_err),
        .rd_frm_err(rd_frm_err), .rd_brk(rd_brk), .rd_ovr(rd_ovr), .rd_empty(rd_empty)
    );

    task automatic bit_time(input logic v);
        rxd = v;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input int nbits, input bit pen,
                             input bit podd, input bit flip, input bit stopv);
        logic p;
        p = podd ^ flip;
        cfg_len = 2'(nbits - 5);
        cfg_par_en = pen;
        cfg_par_odd = podd;
        bit_time(1'b0);
        for (int i = 0; i < nbits; i++) begin
            bit_time(d[i]);
            p = p ^ d[i];
        end
        if (pen) bit_time(p);
        bit_time(stopv);
        bit_time(1'b1);
    endtask

    task automatic check_empty(input string req);
        checks++;
        if (rd_empty !== 1'b1) begin
            errors++;
            $display("FAIL %s: rd_empty=%b expected 1", req, rd_empty);
        end
    endtask

    task automatic check_entry(input string req, input logic [7:0] d, input logic par,
                               input logic frm, input logic brk, input logic ovr);
        logic [12:0] act, exp;
        checks++;
        act = {rd_empty, rd_data, rd_par_err, rd_frm_err, rd_brk, rd_ovr};
        exp = {1'b0, d, par, frm, brk, ovr};
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {empty,data,par,frm,brk,ovr}=%h expected %h", req, act, exp);
        end
        if (!rd_empty) begin
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
    endtask

    task automatic t_reset;
        check_empty("R10 reset");
        rd_en = 1'b1; // R9 read of empty queue
        @(negedge clk);
        rd_en = 1'b0;
        check_empty("R9 empty read");
    endtask

    task automatic t_basic;
        send_char(8'hA5, 8, 0, 0, 0, 1);
        send_char(8'h3C, 8, 0, 0, 0, 1);
        check_entry("R9 order first R3", 8'hA5, 0, 0, 0, 0);
        check_entry("R9 order second", 8'h3C, 0, 0, 0, 0);
        check_empty("R9 drained");
    endtask

    task automatic t_lengths;
        send_char(8'hF6, 5, 0, 0, 0, 1);
        check_entry("R3 len5", 8'h16, 0, 0, 0, 0);
        send_char(8'hE9, 6, 0, 0, 0, 1);
        check_entry("R3 len6", 8'h29, 0, 0, 0, 0);
        send_char(8'hD3, 7, 0, 0, 0, 1);
        check_entry("R3 len7", 8'h53, 0, 0, 0, 0);
    endtask

    task automatic t_parity;
        send_char(8'h5A, 8, 1, 0, 0, 1);
        check_entry("R4 even ok", 8'h5A, 0, 0, 0, 0);
        send_char(8'h07, 7, 1, 1, 0, 1);
        check_entry("R4 odd ok", 8'h07, 0, 0, 0, 0);
        send_char(8'h5A, 8, 1, 0, 1, 1);
        check_entry("R4 even bad", 8'h5A, 1, 0, 0, 0);
        send_char(8'h13, 5, 1, 1, 1, 1);
        check_entry("R4 odd bad", 8'h13, 1, 0, 0, 0);
    endtask

    task automatic t_framing;
        send_char(8'h81, 8, 0, 0, 0, 0);
        check_entry("R5 stop low", 8'h81, 0, 1, 0, 0);
    endtask

    task automatic t_break;
        cfg_len = 2'd3;
        cfg_par_en = 1'b0;
        rxd = 1'b0;
        repeat (12 * BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        check_entry("R6 break entry", 8'h00, 0, 1, 1, 0);
        check_empty("R6 single break entry");
        send_char(8'h42, 8, 0, 0, 0, 1);
        check_entry("R6 recovery", 8'h42, 0, 0, 0, 0);
    endtask

    task automatic t_glitch;
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BIT) @(negedge clk);
        check_empty("R2 glitch rejected");
    endtask

    task automatic t_disabled;
        en = 1'b0;
        send_char(8'h66, 8, 0, 0, 0, 1);
        check_empty("R1 en low");
        en = 1'b1;
        rx_en = 1'b0;
        send_char(8'h77, 8, 0, 0, 0, 1);
        check_empty("R1 rx_en low");
        rx_en = 1'b1;
    endtask

    task automatic t_midfinish;
        fork
            send_char(8'h99, 8, 0, 0, 0, 1);
            begin
                repeat (3 * BIT) @(negedge clk);
                en = 1'b0;
            end
        join
        check_entry("R8 completes after disable", 8'h99, 0, 0, 0, 0);
        en = 1'b1;
    endtask

    task automatic t_overrun;
        for (int i = 1; i <= 9; i++) send_char(8'(8'h10 + i), 8, 0, 0, 0, 1);
        for (int i = 1; i <= 7; i++) check_entry("R7 stored", 8'(8'h10 + i), 0, 0, 0, 0);
        check_entry("R7 ovr on newest", 8'h18, 0, 0, 0, 1);
        check_empty("R7 dropped char");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_lengths();
        t_parity();
        t_framing();
        t_break();
        t_glitch();
        t_disabled();
        t_midfinish();
        t_overrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): run still active, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule